// File: doc/BRIEF.md
# Banked 16-bit Byte-Lane Memory Interface

This block is a memory subsystem on a 16-bit processor bus with a 20-bit byte address. From the memory/IO status line and the active-low read and write strobes it forms four active-low commands: memory read, memory write, I/O read and I/O write. Only the memory commands reach storage. I/O commands are exported for other decoders and never touch the banks.

A full decode of the upper address bits selects one window at base `BASE`. Inside the window, storage is split into two 8-bit banks that share one index taken from the address bits above bit 0. The low bank carries data bits 7..0 and the high bank carries bits 15..8. Address bit 0 and the active-low high-byte enable decide which of the two lanes take part in a cycle. Writes commit on the clock edge. Reads are registered and return one cycle later on fixed lanes. An odd byte always comes back on the upper lane and is not shifted down.

With the default `WIN_LOG2` of 12, the window is C0000h–C0FFFh and each bank holds 2048 bytes. Setting `WIN_LOG2` to 16 gives the full 64 KB window C0000h–CFFFFh with 32K bytes per bank. The behaviour does not change.

Top module: `banked_mem16`

## Requirements
- R1: The strobe outputs are combinational and active low. `mem_rd_n` is low exactly when `mio`=1 and `rd_n`=0. `mem_wr_n` is low exactly when `mio`=1 and `wr_n`=0. `io_rd_n` is low exactly when `mio`=0 and `rd_n`=0. `io_wr_n` is low exactly when `mio`=0 and `wr_n`=0.
- R2: An I/O cycle (`mio`=0) never changes bank contents. An I/O read yields `rd_valid`=0 and `rd_data`=0 after the next edge.
- R3: A cycle selects the banks only when `addr[19:WIN_LOG2]` equals `BASE[19:WIN_LOG2]`; with defaults, this is addresses C0000h–C0FFFh. Outside the window a write changes nothing, and a read yields `rd_data`=0 and `rd_valid`=0.
- R4: Both banks are indexed by `addr[WIN_LOG2-1:1]`, which gives 2^(WIN_LOG2-1) bytes per bank. Distinct index values address independent storage, including the lowest and highest index.
- R5: The low bank stores and returns bits 7..0. The high bank stores and returns bits 15..8. An odd-byte write takes its byte from `wr_data[15:8]`, and an odd-byte read returns it on `rd_data[15:8]`.
- R6: The lane selection is set by the pair (`addr[0]`, `bhe_n`). (0,1) selects only the low bank. (1,0) selects only the high bank. (0,0) selects both banks. (1,1) selects neither bank. A write updates only the selected banks.
- R7: A memory read in the window with at least one lane selected, sampled at a rising edge, sets `rd_valid`=1 after that edge. In that case `rd_data` carries the stored byte for each selected lane and zero for each deselected lane. After any other edge, `rd_valid`=0 and `rd_data`=0.
- R8: A memory write in the window commits at the rising edge on which `mem_wr_n` is low. A read issued in the following cycle returns the new data.
- R9: While `rst_n` is low, `rd_data` is 0 and `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and read capture happen on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the read-output registers |
| addr | input | 20 | Byte address |
| mio | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| bhe_n | input | 1 | Active-low high-byte enable |
| wr_data | input | 16 | Write data, bits 7..0 to the low bank and bits 15..8 to the high bank |
| rd_data | output | 16 | Registered read data, with zero on deselected lanes |
| rd_valid | output | 1 | High for one cycle after an accepted memory read |
| mem_rd_n | output | 1 | Decoded memory-read command, active low |
| mem_wr_n | output | 1 | Decoded memory-write command, active low |
| io_rd_n | output | 1 | Decoded I/O-read command, active low |
| io_wr_n | output | 1 | Decoded I/O-write command, active low |

## Verification
The bench writes single bytes at both parities next to full words and checks that the neighbouring byte survives. A steering fault would corrupt or leak into the other lane, and a shifting fault would return the odd byte on the low lane. Addresses just past the window share the low bits of locations inside it. A partial chip-select decode would therefore alias those writes into real storage, and the bench catches this by reading the location inside the window back. I/O writes to in-window addresses and the (1,1) lane pair are expected to leave memory untouched. A decode that ignored `mio` or the null lane pair would overwrite data, and one that raised `rd_valid` without a selected lane would show up at the valid flag.

// File: rtl/banked_mem16_pkg.sv
package banked_mem16_pkg;

   // Active-low command strobes formed from the bus status.
   typedef struct packed {
      logic mrd_n;
      logic mwr_n;
      logic ird_n;
      logic iwr_n;
   } bus_strobe_t;

   localparam int unsigned LANES  = 2;
   localparam int unsigned LANE_W = 8;

   typedef logic [LANES-1:0] lane_mask_t;

   // Lane 0 follows addr[0] low, lane 1 follows the high-byte enable low.
   function automatic lane_mask_t lanes_of(input logic a0, input logic bhe_n);
      lane_mask_t m;
      m[0] = ~a0;
      m[1] = ~bhe_n;
      return m;
   endfunction

endpackage

// File: rtl/bus_cmd_decode.sv
module bus_cmd_decode
   import banked_mem16_pkg::*;
(
   input  logic        mio,
   input  logic        rd_n,
   input  logic        wr_n,
   output bus_strobe_t strobe
);

   always_comb begin
      strobe.mrd_n = ~( mio & ~rd_n);
      strobe.mwr_n = ~( mio & ~wr_n);
      strobe.ird_n = ~(~mio & ~rd_n);
      strobe.iwr_n = ~(~mio & ~wr_n);
   end

endmodule

// File: rtl/window_select.sv
module window_select #(
   parameter int unsigned       ADDR_W   = 20,
   parameter int unsigned       WIN_LOG2 = 12,
   parameter logic [ADDR_W-1:0] BASE     = 20'hC0000
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);

   generate
      if (WIN_LOG2 >= ADDR_W) begin : g_whole_space
         assign hit = 1'b1;
      end else begin : g_compare
         localparam int unsigned TAG_W = ADDR_W - WIN_LOG2;
         localparam logic [TAG_W-1:0] TAG = BASE[ADDR_W-1:WIN_LOG2];
         assign hit = (addr[ADDR_W-1:WIN_LOG2] == TAG);
      end
   endgenerate

endmodule

// File: rtl/byte_bank.sv
module byte_bank #(
   parameter int unsigned IDX_W  = 11,
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata
);

   localparam int unsigned DEPTH = 1 << IDX_W;

   logic [BYTE_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         store[idx] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (rd_en) begin
         rdata <= store[idx];
      end else begin
         rdata <= '0;
      end
   end

endmodule

// File: rtl/banked_mem16.sv
module banked_mem16
   import banked_mem16_pkg::*;
#(
   parameter int unsigned       ADDR_W   = 20,
   parameter int unsigned       WIN_LOG2 = 12,
   parameter logic [ADDR_W-1:0] BASE     = 20'hC0000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [19:0] addr,
   input  logic        mio,
   input  logic        rd_n,
   input  logic        wr_n,
   input  logic        bhe_n,
   input  logic [15:0] wr_data,
   output logic [15:0] rd_data,
   output logic        rd_valid,
   output logic        mem_rd_n,
   output logic        mem_wr_n,
   output logic        io_rd_n,
   output logic        io_wr_n
);

   localparam int unsigned IDX_W  = WIN_LOG2 - 1;
   localparam int unsigned DATA_W = LANES * LANE_W;

   initial begin
      assert (ADDR_W == 20)
         else $error("banked_mem16: ADDR_W must match the 20-bit port");
      assert (WIN_LOG2 >= 2 && WIN_LOG2 <= ADDR_W)
         else $error("banked_mem16: WIN_LOG2 out of range");
      assert ((BASE & ((ADDR_W'(1) << WIN_LOG2) - ADDR_W'(1))) == '0)
         else $error("banked_mem16: BASE not aligned to window");
      assert (DATA_W == 16)
         else $error("banked_mem16: lane geometry must give 16 bits");
   end

   bus_strobe_t strobe;
   logic        win_hit;
   lane_mask_t  lane_sel;
   logic [IDX_W-1:0] idx;

   bus_cmd_decode u_cmd (
      .mio    (mio),
      .rd_n   (rd_n),
      .wr_n   (wr_n),
      .strobe (strobe)
   );

   window_select #(
      .ADDR_W   (ADDR_W),
      .WIN_LOG2 (WIN_LOG2),
      .BASE     (BASE)
   ) u_win (
      .addr (addr),
      .hit  (win_hit)
   );

   assign lane_sel = lanes_of(addr[0], bhe_n);
   assign idx      = addr[WIN_LOG2-1:1];

   assign mem_rd_n = strobe.mrd_n;
   assign mem_wr_n = strobe.mwr_n;
   assign io_rd_n  = strobe.ird_n;
   assign io_wr_n  = strobe.iwr_n;

   logic mem_rd_go, mem_wr_go;
   assign mem_rd_go = ~strobe.mrd_n & win_hit;
   assign mem_wr_go = ~strobe.mwr_n & win_hit;

   logic [LANE_W-1:0] lane_rd [LANES];

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         byte_bank #(
            .IDX_W  (IDX_W),
            .BYTE_W (LANE_W)
         ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (mem_wr_go & lane_sel[g]),
            .rd_en (mem_rd_go & lane_sel[g]),
            .idx   (idx),
            .wdata (wr_data[g*LANE_W +: LANE_W]),
            .rdata (lane_rd[g])
         );
         assign rd_data[g*LANE_W +: LANE_W] = lane_rd[g];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= mem_rd_go & (|lane_sel);
      end
   end

endmodule

// File: rtl/banked_mem16_chk.sv
module banked_mem16_chk #(
   parameter int unsigned       ADDR_W   = 20,
   parameter int unsigned       WIN_LOG2 = 12,
   parameter logic [ADDR_W-1:0] BASE     = 20'hC0000
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              mio,
   input logic              wr_n,
   input logic              bhe_n,
   input logic              mem_rd_n,
   input logic              mem_wr_n,
   input logic              io_rd_n,
   input logic [15:0]       rd_data,
   input logic              rd_valid
);

   AST_MWR_NEEDS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_wr_n |-> (mio && !wr_n));  // R1

   AST_IO_READ_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !io_rd_n |=> !rd_valid);  // R2

   AST_VALID_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ($past(addr[ADDR_W-1:WIN_LOG2]) == BASE[ADDR_W-1:WIN_LOG2]));  // R3

   AST_HIGH_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && $past(bhe_n)) |-> (rd_data[15:8] == 8'h00));  // R6

   AST_LOW_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && $past(addr[0])) |-> (rd_data[7:0] == 8'h00));  // R6

   AST_VALID_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(!mem_rd_n));  // R7

   AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> (rd_data == 16'h0000));  // R7

endmodule

bind banked_mem16 banked_mem16_chk #(
   .ADDR_W   (ADDR_W),
   .WIN_LOG2 (WIN_LOG2),
   .BASE     (BASE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .addr     (addr),
   .mio      (mio),
   .wr_n     (wr_n),
   .bhe_n    (bhe_n),
   .mem_rd_n (mem_rd_n),
   .mem_wr_n (mem_wr_n),
   .io_rd_n  (io_rd_n),
   .rd_data  (rd_data),
   .rd_valid (rd_valid)
);

// File: tb/tb_banked_mem16.sv
`timescale 1ns/1ps
module tb_banked_mem16;

   localparam int WL    = 12;
   localparam int WORDS = 1 << (WL - 1);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] addr = '0;
   logic        mio = 1'b1, rd_n = 1'b1, wr_n = 1'b1, bhe_n = 1'b1;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        rd_valid, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n;

   int n_checks = 0;
   int n_fail   = 0;

   logic [7:0] m_lo [WORDS];
   logic [7:0] m_hi [WORDS];

   always #4 clk = ~clk;

   banked_mem16 dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .mio(mio), .rd_n(rd_n),
      .wr_n(wr_n), .bhe_n(bhe_n), .wr_data(wr_data), .rd_data(rd_data),
      .rd_valid(rd_valid), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
      .io_rd_n(io_rd_n), .io_wr_n(io_wr_n)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic bit in_win(input logic [19:0] a);
      return a[19:WL] == 8'hC0;
   endfunction

   task automatic model_wr(input logic [19:0] a, input logic b, input logic [15:0] d);
      if (in_win(a)) begin
         if (!a[0]) m_lo[a[WL-1:1]] = d[7:0];
         if (!b)    m_hi[a[WL-1:1]] = d[15:8];
      end
   endtask

   task automatic bus_wr(input logic [19:0] a, input logic b, input logic [15:0] d,
                         input logic m);
      @(negedge clk);
      addr = a; bhe_n = b; wr_data = d; mio = m; wr_n = 1'b0;
      @(negedge clk);
      wr_n = 1'b1; mio = 1'b1;
      if (m) model_wr(a, b, d);
   endtask

   // Issue a read and compare against the byte model after the capturing edge.
   task automatic bus_rd_chk(input string tag, input logic [19:0] a, input logic b);
      logic [15:0] e;
      logic        ev;
      ev = in_win(a) && (!a[0] || !b);
      e  = '0;
      if (in_win(a) && !a[0]) e[7:0]  = m_lo[a[WL-1:1]];
      if (in_win(a) && !b)    e[15:8] = m_hi[a[WL-1:1]];
      @(negedge clk);
      addr = a; bhe_n = b; mio = 1'b1; rd_n = 1'b0;
      @(negedge clk);
      chk({tag, " data"}, 32'(rd_data), 32'(e));
      chk({tag, " valid"}, 32'(rd_valid), 32'(ev));
      rd_n = 1'b1;
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R9 reset rd_data", 32'(rd_data), 32'h0);
      chk("R9 reset rd_valid", 32'(rd_valid), 32'h0);
      chk("R1 idle strobes", 32'({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}), 32'hF);
   endtask

   task automatic t_decode;
      for (int i = 0; i < 8; i++) begin
         logic [3:0] e;
         @(negedge clk);
         mio = i[2]; rd_n = i[1]; wr_n = i[0];
         addr = 20'h00000;
         #1;
         e = {~(i[2] & ~i[1]), ~(i[2] & ~i[0]), ~(~i[2] & ~i[1]), ~(~i[2] & ~i[0])};
         chk("R1 strobe decode", 32'({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}), 32'(e));
      end
      @(negedge clk);
      mio = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
   endtask

   task automatic t_fill;
      for (int w = 0; w < WORDS; w++) begin
         bus_wr(20'hC0000 | 20'(w << 1), 1'b0, 16'(w * 16'h3B1 + 16'h5A0F), 1'b1);
      end
      bus_rd_chk("R4 fill first", 20'hC0000, 1'b0);
      bus_rd_chk("R4 fill last", 20'hC0FFE, 1'b0);
   endtask

   task automatic t_word;
      bus_wr(20'hC0100, 1'b0, 16'hBEEF, 1'b1);
      bus_rd_chk("R8 word readback", 20'hC0100, 1'b0);
      bus_wr(20'hC0100, 1'b0, 16'h1234, 1'b1);
      bus_rd_chk("R8 word overwrite", 20'hC0100, 1'b0);
   endtask

   task automatic t_bytes;
      bus_wr(20'hC0200, 1'b0, 16'hAAAA, 1'b1);
      bus_wr(20'hC0200, 1'b1, 16'h77C3, 1'b1);
      bus_rd_chk("R6 even byte write keeps high", 20'hC0200, 1'b0);
      bus_wr(20'hC0201, 1'b0, 16'h9D11, 1'b1);
      bus_rd_chk("R5 odd byte from upper lane", 20'hC0200, 1'b0);
      bus_rd_chk("R7 even byte read zero upper", 20'hC0200, 1'b1);
      bus_rd_chk("R5 odd byte read on upper lane", 20'hC0201, 1'b0);
   endtask

   task automatic t_none;
      bus_wr(20'hC0301, 1'b1, 16'hFFFF, 1'b1);
      bus_rd_chk("R6 null pair write ignored", 20'hC0300, 1'b0);
      bus_rd_chk("R6 null pair read", 20'hC0301, 1'b1);
   endtask

   task automatic t_window;
      bus_wr(20'hC1400, 1'b0, 16'hDEAD, 1'b1);
      bus_wr(20'hD0400, 1'b0, 16'hCAFE, 1'b1);
      bus_wr(20'h40400, 1'b0, 16'hF00D, 1'b1);
      bus_rd_chk("R3 alias write ignored", 20'hC0400, 1'b0);
      bus_rd_chk("R3 outside read above", 20'hC1400, 1'b0);
      bus_rd_chk("R3 outside read below", 20'hBFFFE, 1'b0);
   endtask

   task automatic t_io;
      bus_wr(20'hC0500, 1'b0, 16'h0BAD, 1'b0);
      bus_rd_chk("R2 io write leaves memory", 20'hC0500, 1'b0);
      @(negedge clk);
      addr = 20'hC0500; bhe_n = 1'b0; mio = 1'b0; rd_n = 1'b0;
      @(negedge clk);
      chk("R2 io read data", 32'(rd_data), 32'h0);
      chk("R2 io read valid", 32'(rd_valid), 32'h0);
      rd_n = 1'b1; mio = 1'b1;
   endtask

   task automatic t_index;
      bus_wr(20'hC0002, 1'b0, 16'h1111, 1'b1);
      bus_wr(20'hC0FFE, 1'b0, 16'h2222, 1'b1);
      bus_wr(20'hC0800, 1'b0, 16'h3333, 1'b1);
      bus_rd_chk("R4 index low", 20'hC0002, 1'b0);
      bus_rd_chk("R4 index high", 20'hC0FFE, 1'b0);
      bus_rd_chk("R4 index mid", 20'hC0800, 1'b0);
      @(negedge clk);
      @(negedge clk);
      chk("R7 idle after read", 32'({rd_valid, rd_data}), 32'h0);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            t_reset;
            rst_n = 1'b1;
            t_decode;
            t_fill;
            t_word;
            t_bytes;
            t_none;
            t_window;
            t_io;
            t_index;
         end
         begin
            repeat (100000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      disable fork;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule